// File: doc/BRIEF.md
# Open-Row-First DRAM Read Scheduler

This block sits between a read-request stream and one DRAM bank. Requests carry a row, a column and a size flag: a full 64-byte line or a 32-byte half line. They wait in a small queue. Whenever the bank is free, the scheduler picks one queued request and drives the bank through the precharge, activate and column-read commands that request needs, spacing each command with down-counters. It then marks the data beats as they return. Commands leave on a plain command port, with one command or a no-operation each cycle. The returning data is announced on a response port.

The selection favours the row that is already open in the row buffer. A queued request to that row is chosen ahead of any older request to another row, and it costs only a column read. If no queued request matches the open row, the oldest request is taken. It is preceded by a precharge when some other row is open, or by an activate alone when the bank is closed. The open row is left open after every access. Request age is the queue position: entries shift down toward slot 0 as older ones leave. At most one request is in service at a time.

Back-pressure rules:
- Requests enter on a valid/ready handshake. An entry is taken on a clock edge where `req_valid` and `req_ready` are both high.
- `req_ready` is low exactly while the queue holds `DEPTH` entries. A request can enter in the same cycle that another is picked.
- The response port has no ready signal. Once a read is issued, its beats arrive on fixed cycles and cannot be stalled.

Top module: `dram_rowhit_sched`

## Requirements
- R1: After reset, the queue is empty, `req_ready` is 1, `cmd_kind` is 0 (no-op), `rsp_valid` is 0 and no row is open. The first request is therefore served with an activate and no precharge.
- R2: `req_ready` is 0 exactly while `DEPTH` requests are queued. A request is taken only on an edge where `req_valid` and `req_ready` are both 1.
- R3: When a request is picked and one or more queued requests target the open row, the oldest of those is served before any older request that targets another row.
- R4: When no queued request targets the open row, the oldest queued request is served.
- R5: A request to the open row issues only a column read, with `cmd_kind` = 3 and `cmd_col` set to its column. No precharge and no activate are issued for it.
- R6: A request served while no row is open issues an activate (`cmd_kind` = 2, `cmd_row` = its row). The read follows exactly `CL` cycles later.
- R7: A request served while a different row is open issues a precharge (`cmd_kind` = 1). The activate follows exactly `T_RP` cycles later, and the read follows `CL` cycles after the activate.
- R8: The first data beat comes exactly `CL` cycles after the read command. Beats then occupy consecutive cycles: `BURST_CYC` cycles (4 by default, eight double-rate beats of 64 bits) for a full line when `req_half` = 0, and `BURST_CYC/2` cycles for a half line when `req_half` = 1.
- R9: During a transfer, `rsp_row` and `rsp_col` hold the served request's row and column. `rsp_last` is 1 only on the final beat.
- R10: No command is issued while data beats are returning. The next request's first command comes after the previous request's final beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Queue can take a request |
| req_row | input | ROW_W | Row of the request |
| req_col | input | COL_W | Column of the request |
| req_half | input | 1 | 1 = 32-byte half line, 0 = 64-byte line |
| cmd_kind | output | 2 | Bank command: 0 no-op, 1 precharge, 2 activate, 3 read |
| cmd_row | output | ROW_W | Row address, meaningful with an activate |
| cmd_col | output | COL_W | Column address, meaningful with a read |
| rsp_valid | output | 1 | A data beat pair is returning this cycle |
| rsp_last | output | 1 | Final beat cycle of the transfer |
| rsp_row | output | ROW_W | Row of the request being returned |
| rsp_col | output | COL_W | Column of the request being returned |

## Verification
The bound checker watches the command timing on every cycle. It checks the precharge-to-activate, activate-to-read and read-to-data spacing, keeps the command bus quiet during transfers, holds the response identity through a burst, and bounds the number of outstanding requests. The choice of which request goes next can only be shown by the bench. It queues batches behind a request in service, and the order can only be judged against the queue contents at the moment of each pick, so it cannot be checked from one cycle. The bench also alone confirms that full and half transfers have the right beat counts for each request, and that each command carries the right address.

// File: rtl/rsched_pkg.sv
package rsched_pkg;

  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_PRE = 2'd1,
    CMD_ACT = 2'd2,
    CMD_RD  = 2'd3
  } cmd_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PRE,
    PH_ACT,
    PH_CAS,
    PH_XFER
  } phase_e;

endpackage

// File: rtl/rsched_queue.sv
module rsched_queue #(
  parameter int DEPTH = 4,
  parameter int ROW_W = 3,
  parameter int COL_W = 4,
  parameter int IW    = 2,
  parameter int CW    = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        push_en,
  input  logic [ROW_W-1:0]            push_row,
  input  logic [COL_W-1:0]            push_col,
  input  logic                        push_half,
  input  logic                        pop_en,
  input  logic [IW-1:0]               pop_idx,
  output logic [DEPTH-1:0][ROW_W-1:0] q_row,
  output logic [DEPTH-1:0][COL_W-1:0] q_col,
  output logic [DEPTH-1:0]            q_half,
  output logic [CW-1:0]               q_cnt,
  output logic                        full
);

  logic [DEPTH-1:0][ROW_W-1:0] row_q, row_d;
  logic [DEPTH-1:0][COL_W-1:0] col_q, col_d;
  logic [DEPTH-1:0]            half_q, half_d;
  logic [CW-1:0]               cnt_q, cnt_d, cnt_mid;

  // Slot 0 is the oldest entry; removal closes the gap, arrivals append.
  always_comb begin
    row_d  = row_q;
    col_d  = col_q;
    half_d = half_q;
    for (int i = 0; i < DEPTH - 1; i++) begin
      if (pop_en && (IW'(i) >= pop_idx)) begin
        row_d[i]  = row_q[i+1];
        col_d[i]  = col_q[i+1];
        half_d[i] = half_q[i+1];
      end
    end
    cnt_mid = cnt_q - CW'(pop_en);
    for (int i = 0; i < DEPTH; i++) begin
      if (push_en && (CW'(i) == cnt_mid)) begin
        row_d[i]  = push_row;
        col_d[i]  = push_col;
        half_d[i] = push_half;
      end
    end
    cnt_d = cnt_mid + CW'(push_en);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q  <= '0;
      col_q  <= '0;
      half_q <= '0;
      cnt_q  <= '0;
    end else begin
      row_q  <= row_d;
      col_q  <= col_d;
      half_q <= half_d;
      cnt_q  <= cnt_d;
    end
  end

  assign q_row  = row_q;
  assign q_col  = col_q;
  assign q_half = half_q;
  assign q_cnt  = cnt_q;
  assign full   = (cnt_q == CW'(DEPTH));

endmodule

// File: rtl/rsched_pick.sv
module rsched_pick #(
  parameter int DEPTH = 4,
  parameter int ROW_W = 3,
  parameter int IW    = 2,
  parameter int CW    = 3
) (
  input  logic [DEPTH-1:0][ROW_W-1:0] q_row,
  input  logic [CW-1:0]               q_cnt,
  input  logic                        open_vld,
  input  logic [ROW_W-1:0]            open_row,
  output logic [IW-1:0]               sel_idx,
  output logic                        sel_hit,
  output logic                        sel_any
);

  logic [DEPTH-1:0] hit;

  for (genvar g = 0; g < DEPTH; g++) begin : g_hit
    assign hit[g] = (CW'(g) < q_cnt) && open_vld && (q_row[g] == open_row);
  end

  // Lowest-slot hit wins; with no hit, slot 0 (oldest) is taken.
  always_comb begin
    sel_idx = '0;
    sel_hit = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hit[i]) begin
        sel_idx = IW'(i);
        sel_hit = 1'b1;
      end
    end
  end

  assign sel_any = (q_cnt != '0);

endmodule

// File: rtl/rsched_ctrl.sv
module rsched_ctrl
  import rsched_pkg::*;
#(
  parameter int ROW_W     = 3,
  parameter int COL_W     = 4,
  parameter int CL        = 4,
  parameter int T_RP      = 3,
  parameter int BURST_CYC = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_any,
  input  logic             sel_hit,
  input  logic [ROW_W-1:0] sel_row,
  input  logic [COL_W-1:0] sel_col,
  input  logic             sel_half,
  output logic             pop,
  output logic             open_vld,
  output logic [ROW_W-1:0] open_row,
  output cmd_e             cmd_kind,
  output logic [ROW_W-1:0] cmd_row,
  output logic [COL_W-1:0] cmd_col,
  output logic             rsp_valid,
  output logic             rsp_last,
  output logic [ROW_W-1:0] rsp_row,
  output logic [COL_W-1:0] rsp_col
);

  localparam int LINE_CYC = BURST_CYC;
  localparam int HALF_CYC = BURST_CYC / 2;
  localparam int MAXW_A   = (CL > T_RP) ? CL : T_RP;
  localparam int MAXW     = (MAXW_A > LINE_CYC) ? MAXW_A : LINE_CYC;
  localparam int WW       = $clog2(MAXW + 1);

  phase_e           ph_q;
  logic [WW-1:0]    wt_q;
  cmd_e             cmd_q;
  logic [ROW_W-1:0] crow_q, orow_q, cur_row_q;
  logic [COL_W-1:0] ccol_q, cur_col_q;
  logic             ovld_q, cur_half_q;
  logic             wt_done;

  assign wt_done = (wt_q == '0);
  assign pop     = (ph_q == PH_IDLE) && sel_any;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q       <= PH_IDLE;
      wt_q       <= '0;
      cmd_q      <= CMD_NOP;
      crow_q     <= '0;
      ccol_q     <= '0;
      ovld_q     <= 1'b0;
      orow_q     <= '0;
      cur_row_q  <= '0;
      cur_col_q  <= '0;
      cur_half_q <= 1'b0;
    end else begin
      cmd_q <= CMD_NOP;
      case (ph_q)
        PH_IDLE: begin
          if (sel_any) begin
            cur_row_q  <= sel_row;
            cur_col_q  <= sel_col;
            cur_half_q <= sel_half;
            if (sel_hit) begin
              cmd_q  <= CMD_RD;
              ccol_q <= sel_col;
              ph_q   <= PH_CAS;
              wt_q   <= WW'(CL - 1);
            end else if (ovld_q) begin
              cmd_q  <= CMD_PRE;
              ph_q   <= PH_PRE;
              wt_q   <= WW'(T_RP - 1);
              ovld_q <= 1'b0;
            end else begin
              cmd_q  <= CMD_ACT;
              crow_q <= sel_row;
              ph_q   <= PH_ACT;
              wt_q   <= WW'(CL - 1);
              ovld_q <= 1'b1;
              orow_q <= sel_row;
            end
          end
        end
        PH_PRE: begin
          if (wt_done) begin
            cmd_q  <= CMD_ACT;
            crow_q <= cur_row_q;
            ph_q   <= PH_ACT;
            wt_q   <= WW'(CL - 1);
            ovld_q <= 1'b1;
            orow_q <= cur_row_q;
          end else begin
            wt_q <= wt_q - 1'b1;
          end
        end
        PH_ACT: begin
          if (wt_done) begin
            cmd_q  <= CMD_RD;
            ccol_q <= cur_col_q;
            ph_q   <= PH_CAS;
            wt_q   <= WW'(CL - 1);
          end else begin
            wt_q <= wt_q - 1'b1;
          end
        end
        PH_CAS: begin
          if (wt_done) begin
            ph_q <= PH_XFER;
            wt_q <= cur_half_q ? WW'(HALF_CYC - 1) : WW'(LINE_CYC - 1);
          end else begin
            wt_q <= wt_q - 1'b1;
          end
        end
        PH_XFER: begin
          if (wt_done) ph_q <= PH_IDLE;
          else         wt_q <= wt_q - 1'b1;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign open_vld  = ovld_q;
  assign open_row  = orow_q;
  assign cmd_kind  = cmd_q;
  assign cmd_row   = crow_q;
  assign cmd_col   = ccol_q;
  assign rsp_valid = (ph_q == PH_XFER);
  assign rsp_last  = (ph_q == PH_XFER) && wt_done;
  assign rsp_row   = cur_row_q;
  assign rsp_col   = cur_col_q;

endmodule

// File: rtl/dram_rowhit_sched.sv
module dram_rowhit_sched #(
  parameter int DEPTH     = 4,
  parameter int ROW_W     = 3,
  parameter int COL_W     = 4,
  parameter int CL        = 4,
  parameter int T_RP      = 3,
  parameter int BURST_CYC = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic             req_half,
  output logic [1:0]       cmd_kind,
  output logic [ROW_W-1:0] cmd_row,
  output logic [COL_W-1:0] cmd_col,
  output logic             rsp_valid,
  output logic             rsp_last,
  output logic [ROW_W-1:0] rsp_row,
  output logic [COL_W-1:0] rsp_col
);

  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0][ROW_W-1:0] q_row;
  logic [DEPTH-1:0][COL_W-1:0] q_col;
  logic [DEPTH-1:0]            q_half;
  logic [CW-1:0]               q_cnt;
  logic                        full, push_en, pop;
  logic [IW-1:0]               sel_idx;
  logic                        sel_hit, sel_any, open_vld;
  logic [ROW_W-1:0]            open_row;
  rsched_pkg::cmd_e            cmd_e_w;

  assign req_ready = !full;
  assign push_en   = req_valid && !full;

  rsched_queue #(
    .DEPTH(DEPTH), .ROW_W(ROW_W), .COL_W(COL_W), .IW(IW), .CW(CW)
  ) u_queue (
    .clk(clk), .rst(rst),
    .push_en(push_en), .push_row(req_row), .push_col(req_col), .push_half(req_half),
    .pop_en(pop), .pop_idx(sel_idx),
    .q_row(q_row), .q_col(q_col), .q_half(q_half), .q_cnt(q_cnt), .full(full)
  );

  rsched_pick #(
    .DEPTH(DEPTH), .ROW_W(ROW_W), .IW(IW), .CW(CW)
  ) u_pick (
    .q_row(q_row), .q_cnt(q_cnt), .open_vld(open_vld), .open_row(open_row),
    .sel_idx(sel_idx), .sel_hit(sel_hit), .sel_any(sel_any)
  );

  rsched_ctrl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .CL(CL), .T_RP(T_RP), .BURST_CYC(BURST_CYC)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .sel_any(sel_any), .sel_hit(sel_hit),
    .sel_row(q_row[sel_idx]), .sel_col(q_col[sel_idx]), .sel_half(q_half[sel_idx]),
    .pop(pop), .open_vld(open_vld), .open_row(open_row),
    .cmd_kind(cmd_e_w), .cmd_row(cmd_row), .cmd_col(cmd_col),
    .rsp_valid(rsp_valid), .rsp_last(rsp_last), .rsp_row(rsp_row), .rsp_col(rsp_col)
  );

  assign cmd_kind = cmd_e_w;

endmodule

// File: rtl/dram_rowhit_sched_chk.sv
module dram_rowhit_sched_chk #(
  parameter int DEPTH = 4,
  parameter int COL_W = 4,
  parameter int CL    = 4,
  parameter int T_RP  = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic [1:0]       cmd_kind,
  input logic             rsp_valid,
  input logic             rsp_last,
  input logic [COL_W-1:0] rsp_col
);

  localparam logic [1:0] K_NOP = 2'd0;
  localparam logic [1:0] K_PRE = 2'd1;
  localparam logic [1:0] K_ACT = 2'd2;
  localparam logic [1:0] K_RD  = 2'd3;

  logic [7:0] gap_q, rd_gap_q, out_q;
  logic [1:0] last_q;
  logic       vld_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q      <= '0;
      rd_gap_q   <= '0;
      out_q      <= '0;
      last_q     <= K_NOP;
      vld_prev_q <= 1'b0;
    end else begin
      if (cmd_kind != K_NOP) begin
        gap_q  <= 8'd1;
        last_q <= cmd_kind;
      end else if (gap_q != 8'hff) begin
        gap_q <= gap_q + 8'd1;
      end
      if (cmd_kind == K_RD)       rd_gap_q <= 8'd1;
      else if (rd_gap_q != 8'hff) rd_gap_q <= rd_gap_q + 8'd1;
      out_q <= out_q + 8'(req_valid && req_ready) - 8'(rsp_valid && rsp_last);
      vld_prev_q <= rsp_valid;
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    $fell(rst) |-> (cmd_kind == K_NOP && !rsp_valid && req_ready));

  assert_outstanding_R2: assert property (@(posedge clk) disable iff (rst)
    out_q <= 8'(DEPTH + 1));

  assert_act_to_rd_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd_kind == K_RD && last_q == K_ACT) |-> gap_q == 8'(CL));

  assert_pre_then_act_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd_kind != K_NOP && last_q == K_PRE) |-> (cmd_kind == K_ACT && gap_q == 8'(T_RP)));

  assert_rd_to_data_R8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !vld_prev_q) |-> rd_gap_q == 8'(CL));

  assert_last_in_burst_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_last |-> rsp_valid);

  assert_burst_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_last) |=> (rsp_valid && $stable(rsp_col)));

  assert_bus_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> cmd_kind == K_NOP);

endmodule

bind dram_rowhit_sched dram_rowhit_sched_chk #(
  .DEPTH(DEPTH), .COL_W(COL_W), .CL(CL), .T_RP(T_RP)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .cmd_kind(cmd_kind), .rsp_valid(rsp_valid), .rsp_last(rsp_last), .rsp_col(rsp_col)
);

// File: tb/dram_rowhit_sched_test.sv
module dram_rowhit_sched_test;

  localparam int DEPTH = 4, ROW_W = 3, COL_W = 4, CL = 4, T_RP = 3, BURST_CYC = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_half = 1'b0;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic req_ready, rsp_valid, rsp_last;
  logic [1:0] cmd_kind;
  logic [ROW_W-1:0] cmd_row, rsp_row;
  logic [COL_W-1:0] cmd_col, rsp_col;

  always #2.5 clk = ~clk;

  dram_rowhit_sched #(.DEPTH(DEPTH), .ROW_W(ROW_W), .COL_W(COL_W), .CL(CL),
                      .T_RP(T_RP), .BURST_CYC(BURST_CYC)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_row(req_row), .req_col(req_col), .req_half(req_half),
    .cmd_kind(cmd_kind), .cmd_row(cmd_row), .cmd_col(cmd_col),
    .rsp_valid(rsp_valid), .rsp_last(rsp_last), .rsp_row(rsp_row), .rsp_col(rsp_col));

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int cyc = 0;
  int nc = 0, nb = 0, n_last = 0;
  int lk[256], lcy[256], lrow[256], lcol[256];
  int bcy[256], bcol[256], brow[256], blast[256];
  int b_row[8], b_col[8], b_half[8];
  int mo_vld = 0, mo_row = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // Monitor: samples outputs mid-cycle.
  initial forever begin
    @(negedge clk);
    cyc++;
    if (cmd_kind != 2'd0 && nc < 256) begin
      lk[nc] = int'(cmd_kind); lcy[nc] = cyc; lrow[nc] = int'(cmd_row);
      lcol[nc] = int'(cmd_col); nc++;
    end
    if (rsp_valid && nb < 256) begin
      bcy[nb] = cyc; bcol[nb] = int'(rsp_col); brow[nb] = int'(rsp_row);
      blast[nb] = int'(rsp_last); nb++;
      if (rsp_last) n_last++;
    end
  end

  function automatic int k_at(input int i);
    return (i < nc) ? lk[i] : -1;
  endfunction

  task automatic run_batch(input int n);
    int used[8];
    int ci, bi, prev_end, guard;
    nc = 0; nb = 0; n_last = 0;
    for (int i = 0; i < n; i++) begin
      req_valid = 1'b1;
      req_row = ROW_W'(b_row[i]); req_col = COL_W'(b_col[i]); req_half = b_half[i][0];
      while (!req_ready) @(negedge clk);
      @(negedge clk);
    end
    req_valid = 1'b0;
    if (n == DEPTH + 1)
      chk(req_ready == 1'b0, "R2", "ready with full queue", int'(req_ready), 0);
    guard = 0;
    while (n_last < n && guard < 2000) begin @(negedge clk); guard++; end
    repeat (3) @(negedge clk);
    chk(n_last == n, "R9", "completed transfers", n_last, n);
    chk(req_ready == 1'b1, "R2", "ready after drain", int'(req_ready), 1);
    // Analyse against the policy.
    for (int i = 0; i < 8; i++) used[i] = 0;
    ci = 0; bi = 0; prev_end = -1;
    for (int j = 0; j < n; j++) begin
      int idx, r, c, nbt, rd_c, first_c;
      bit hit, any_hit;
      idx = -1; any_hit = 0;
      if (j == 0) idx = 0;
      else begin
        for (int i = 1; i < n; i++)
          if (!used[i] && idx < 0 && mo_vld != 0 && b_row[i] == mo_row) begin
            idx = i; any_hit = 1;
          end
        for (int i = 1; i < n; i++)
          if (!used[i] && idx < 0) idx = i;
      end
      used[idx] = 1;
      r = b_row[idx]; c = b_col[idx];
      hit = (mo_vld != 0) && (mo_row == r);
      first_c = (ci < nc) ? lcy[ci] : -1;
      if (prev_end >= 0)
        chk(first_c > prev_end, "R10", "command before prior burst ended", first_c, prev_end + 1);
      if (hit) begin
        chk(k_at(ci) == 3, "R5", "open-row request command", k_at(ci), 3);
        rd_c = (ci < nc) ? lcy[ci] : -1;
      end else begin
        int act_c;
        if (mo_vld != 0) begin
          chk(k_at(ci) == 1, "R7", "precharge for row conflict", k_at(ci), 1);
          act_c = (ci < nc) ? lcy[ci] : -1; ci++;
          chk(k_at(ci) == 2 && ci < nc && lcy[ci] == act_c + T_RP, "R7",
              "precharge-to-activate cycle", (ci < nc) ? lcy[ci] : -1, act_c + T_RP);
        end else begin
          chk(k_at(ci) == 2, "R6", "activate on closed bank", k_at(ci), 2);
        end
        chk(ci < nc && lrow[ci] == r, "R6", "activate row", (ci < nc) ? lrow[ci] : -1, r);
        act_c = (ci < nc) ? lcy[ci] : -1; ci++;
        chk(k_at(ci) == 3 && ci < nc && lcy[ci] == act_c + CL, "R6",
            "activate-to-read cycle", (ci < nc) ? lcy[ci] : -1, act_c + CL);
        rd_c = (ci < nc) ? lcy[ci] : -1;
      end
      chk(ci < nc && lcol[ci] == c, (j > 0 && any_hit) ? "R3" : "R4",
          "read column (service order)", (ci < nc) ? lcol[ci] : -1, c);
      ci++;
      nbt = (b_half[idx] != 0) ? BURST_CYC / 2 : BURST_CYC;
      for (int k = 0; k < nbt; k++) begin
        int bc;
        bc = (bi < nb) ? bcy[bi] : -1;
        chk(bc == rd_c + CL + k, "R8", "beat cycle", bc, rd_c + CL + k);
        chk(bi < nb && bcol[bi] == c && brow[bi] == r, "R9", "beat column",
            (bi < nb) ? bcol[bi] : -1, c);
        chk(bi < nb && blast[bi] == ((k == nbt - 1) ? 1 : 0), "R9", "last flag",
            (bi < nb) ? blast[bi] : -1, (k == nbt - 1) ? 1 : 0);
        bi++;
      end
      prev_end = (bi > 0 && bi <= nb) ? bcy[bi-1] : prev_end;
      mo_vld = 1; mo_row = r;
    end
    chk(ci == nc, "R10", "command count", nc, ci);
    chk(bi == nb, "R8", "beat count", nb, bi);
  endtask

  task automatic set_req(input int i, input int r, input int c, input int h);
    b_row[i] = r; b_col[i] = c; b_half[i] = h;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cmd_kind == 2'd0, "R1", "command after reset", int'(cmd_kind), 0);
    chk(rsp_valid == 1'b0, "R1", "response after reset", int'(rsp_valid), 0);
    chk(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
    // Closed bank first, then hits overtake older conflicts.
    set_req(0, 1, 0, 0); set_req(1, 2, 1, 0); set_req(2, 1, 2, 0);
    set_req(3, 3, 3, 0); set_req(4, 1, 4, 0);
    run_batch(5);
    // Only conflicts: strict age order.
    set_req(0, 4, 5, 0); set_req(1, 5, 6, 1); set_req(2, 6, 7, 0); set_req(3, 7, 8, 1);
    run_batch(4);
    // Half lines hitting the open row.
    set_req(0, 7, 9, 1); set_req(1, 7, 10, 0); set_req(2, 2, 11, 1); set_req(3, 7, 12, 1);
    run_batch(4);
    // Hit, then no hit falls back to oldest, then hits again.
    set_req(0, 2, 13, 0); set_req(1, 5, 14, 0); set_req(2, 5, 15, 1);
    set_req(3, 2, 0, 0); set_req(4, 5, 1, 1);
    run_batch(5);
    // Arithmetic sweep over small patterns.
    for (int p = 0; p < 28; p++) begin
      int n;
      n = 2 + (p % 4);
      for (int i = 0; i < n; i++)
        set_req(i, (p + i * i * ((p % 3) + 1)) % 3, (p * 5 + i) % 16,
                ((p + i * 3) % 4 == 1) ? 1 : 0);
      run_batch(n);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule